// File: doc/BRIEF.md
# Converter Power-Up Reset Sequencer

This block generates the active-low reset for an analog-to-digital converter core, along with a power-ready status flag. Once both the converter enable and the software run bit are high, the block holds the core's reset low for a fixed base count. It then adds a programmable extension count, and only after that releases reset and raises power-ready. The extension value is staged by software. It moves into an active register only when software writes 1 to a load bit, and that bit clears itself on the next cycle.

The sequencer is a three-state machine:

- `SEQ_OFF`: reset asserted, not ready.
- `SEQ_HOLD`: reset asserted, down-counter running.
- `SEQ_RUN`: reset released, ready.

It has four named transitions:

- `OFF->HOLD` (start): taken when enable and run bit are both high. It loads the counter from the active extension.
- `HOLD->HOLD` (tick): taken while the counter has not reached its last step.
- `HOLD->RUN` (release): taken on the last step.
- `ANY->OFF` (abort): taken whenever enable or run bit is low.

The reset output is also gated directly by enable and run bit. Dropping either one therefore asserts reset in the same cycle.

Top module: `adc_rst_seq`

## Requirements
- R1: After system reset, `conv_rst_n_o`=0, `pwr_rdy_o`=0, `load_bit_o`=0 and `ext_active_o`=0.
- R2: With active extension 0, a start is sampled at a rising edge. Reset stays low through the following 5 edges and goes high after the 6th edge counted from and including the sampling edge.
- R3: With active extension N (0..63), reset and power-ready both go high after edge N+6, counted from and including the start-sampling edge, and not earlier.
- R4: While `soft_run_i`=0, reset stays low and power-ready stays 0 whatever `conv_en_i` does; a start needs both inputs at 1.
- R5: `pwr_rdy_o` is 1 exactly while the sequencer is released; it rises in the same cycle reset is released.
- R6: Dropping `conv_en_i` drives `conv_rst_n_o` to 0 in the same cycle and clears `pwr_rdy_o` after the next edge. Re-enabling restarts the full N+6 count.
- R7: The extension is captured at the start edge, so a load that commits during a count does not change that count's length.
- R8: A write pulse on `load_wr_i` sets `load_bit_o` to 1 after that edge for exactly one cycle. At the next edge the bit reads 0 and `ext_active_o` takes the value of `ext_stage_i`.
- R9: Changes on `ext_stage_i` without a load write leave `ext_active_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| conv_en_i | input | 1 | Converter enable |
| soft_run_i | input | 1 | Software run bit; 0 forces the core reset low |
| ext_stage_i | input | EXT_W | Staged reset-hold extension |
| load_wr_i | input | 1 | Write of 1 to the load bit |
| conv_rst_n_o | output | 1 | Active-low reset to the converter core |
| pwr_rdy_o | output | 1 | Power-ready status |
| load_bit_o | output | 1 | Read-back of the self-clearing load bit |
| ext_active_o | output | EXT_W | Active extension value |

## Verification
The bench builds the block with its defaults, EXT_W=6 and BASE_HOLD=6. This makes the full extension range reachable, up to the longest hold of 69 cycles. A vector table sweeps extensions that include 0, 1 and 63, and times each release edge by edge. Directed tests then cover the software run bit, an enable drop during run and during hold, a load that commits mid-count, and staged changes made without a load.

// File: rtl/adc_rst_pkg.sv
package adc_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_rst_cfg.sv
module adc_rst_cfg #(
    parameter int EXT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr_i,
    input  logic [EXT_W-1:0] ext_stage_i,
    output logic             load_bit_o,
    output logic [EXT_W-1:0] ext_active_o
);

    logic             load_q;
    logic [EXT_W-1:0] active_q;

    // Load bit: set by a write, cleared by the commit cycle; the commit
    // takes priority so the bit is never high two cycles in a row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= 1'b0;
        end else if (load_q) begin
            load_q <= 1'b0;
        end else if (load_wr_i) begin
            load_q <= 1'b1;
        end
    end

    // Active register: copied from the staged value only on commit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (load_q) begin
            active_q <= ext_stage_i;
        end
    end

    assign load_bit_o   = load_q;
    assign ext_active_o = active_q;

    AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> !load_q); // R8

    AST_ACTIVE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_q |=> $stable(active_q)); // R9

endmodule

// File: rtl/adc_rst_timer.sv
module adc_rst_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0)); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/adc_rst_fsm.sv
module adc_rst_fsm
    import adc_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic last_i,
    output logic tmr_load_o,
    output logic tmr_dec_o,
    output logic conv_rst_n_o,
    output logic pwr_rdy_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF:  if (go_i) state_d = SEQ_HOLD;                 // start
            SEQ_HOLD: if (!go_i) state_d = SEQ_OFF;                 // abort
                      else if (last_i) state_d = SEQ_RUN;           // release
            SEQ_RUN:  if (!go_i) state_d = SEQ_OFF;                 // abort
            default:  state_d = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        tmr_load_o   = 1'b0;
        tmr_dec_o    = 1'b0;
        conv_rst_n_o = 1'b0;
        pwr_rdy_o    = 1'b0;
        unique case (state_q)
            SEQ_OFF:  tmr_load_o = go_i;
            SEQ_HOLD: tmr_dec_o  = go_i && !last_i;                 // tick
            SEQ_RUN: begin
                conv_rst_n_o = go_i;
                pwr_rdy_o    = 1'b1;
            end
            default: ;
        endcase
    end

    AST_DROP_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (state_q == SEQ_OFF)); // R6

    AST_NO_EARLY_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_OFF) |=> !pwr_rdy_o); // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD && go_i && last_i) |=> pwr_rdy_o); // R3

endmodule

// File: rtl/adc_rst_seq.sv
module adc_rst_seq #(
    parameter int EXT_W     = 6,
    parameter int BASE_HOLD = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_en_i,
    input  logic             soft_run_i,
    input  logic [EXT_W-1:0] ext_stage_i,
    input  logic             load_wr_i,
    output logic             conv_rst_n_o,
    output logic             pwr_rdy_o,
    output logic             load_bit_o,
    output logic [EXT_W-1:0] ext_active_o
);

    localparam int MAX_HOLD = (1 << EXT_W) - 1 + BASE_HOLD;
    localparam int CNT_W    = $clog2(MAX_HOLD + 1);

    logic             go;
    logic             tmr_load, tmr_dec, tmr_last;
    logic [CNT_W-1:0] hold_len;

    assign go       = conv_en_i & soft_run_i;
    assign hold_len = CNT_W'(ext_active_o) + CNT_W'(BASE_HOLD - 1);

    adc_rst_cfg #(.EXT_W(EXT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_wr_i    (load_wr_i),
        .ext_stage_i  (ext_stage_i),
        .load_bit_o   (load_bit_o),
        .ext_active_o (ext_active_o)
    );

    adc_rst_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (hold_len),
        .dec_i      (tmr_dec),
        .last_o     (tmr_last)
    );

    adc_rst_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .last_i       (tmr_last),
        .tmr_load_o   (tmr_load),
        .tmr_dec_o    (tmr_dec),
        .conv_rst_n_o (conv_rst_n_o),
        .pwr_rdy_o    (pwr_rdy_o)
    );

    AST_RST_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rst_n_o |-> pwr_rdy_o); // R5

    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_run_i |-> !conv_rst_n_o); // R4

endmodule

// File: tb/adc_rst_seq_test.sv
module adc_rst_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int EXT_W      = 6;
    localparam int BASE       = 6;
    localparam int NVEC       = 6;
    localparam int VEC_EXT [NVEC] = '{0, 1, 5, 22, 40, 63};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             conv_en = 1'b0;
    logic             soft_run = 1'b0;
    logic [EXT_W-1:0] ext_stage = '0;
    logic             load_wr = 1'b0;
    logic             conv_rst_n, pwr_rdy, load_bit;
    logic [EXT_W-1:0] ext_active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_rst_seq #(.EXT_W(EXT_W), .BASE_HOLD(BASE)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_en_i    (conv_en),
        .soft_run_i   (soft_run),
        .ext_stage_i  (ext_stage),
        .load_wr_i    (load_wr),
        .conv_rst_n_o (conv_rst_n),
        .pwr_rdy_o    (pwr_rdy),
        .load_bit_o   (load_bit),
        .ext_active_o (ext_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load a staged value; leaves the clock at a falling edge.
    task automatic do_load(input int val, input string req);
        @(negedge clk);
        ext_stage = EXT_W'(val);
        load_wr   = 1'b1;
        @(negedge clk);
        load_wr   = 1'b0;
        chk({req, " load bit set"}, int'(load_bit), 1);
        @(negedge clk);
        chk({req, " load bit cleared"}, int'(load_bit), 0);
        chk({req, " active value"}, int'(ext_active), val);
    endtask

    // Start at the next edge and time the release edge by edge.
    task automatic run_and_time(input int exp_edges, input string req, input bit pulse_load);
        @(negedge clk);
        conv_en  = 1'b1;
        soft_run = 1'b1;
        if (pulse_load) load_wr = 1'b1;
        for (int i = 1; i <= exp_edges; i++) begin
            @(negedge clk);
            load_wr = 1'b0;
            if (i == exp_edges - 1) begin
                chk({req, " reset still low"}, int'(conv_rst_n), 0);
                chk({req, " ready still low"}, int'(pwr_rdy), 0);
            end
        end
        chk({req, " reset released"}, int'(conv_rst_n), 1);
        chk({req, " ready high"}, int'(pwr_rdy), 1);
    endtask

    task automatic stop_en();
        @(negedge clk);
        conv_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 conv_rst_n", int'(conv_rst_n), 0);
        chk("R1 pwr_rdy", int'(pwr_rdy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 load_bit", int'(load_bit), 0);
        chk("R1 ext_active", int'(ext_active), 0);

        // R2: base hold with zero extension
        run_and_time(BASE, "R2", 1'b0);
        stop_en();

        // R3: table of extensions
        for (int v = 0; v < NVEC; v++) begin
            do_load(VEC_EXT[v], "R8");
            run_and_time(VEC_EXT[v] + BASE, "R3", 1'b0);
            stop_en();
            chk("R3 ready cleared", int'(pwr_rdy), 0);
        end

        // R9: staged change without a load
        @(negedge clk);
        ext_stage = 6'd9;
        repeat (3) @(negedge clk);
        chk("R9 active unchanged", int'(ext_active), 63);

        // R4: run bit low blocks release
        do_load(2, "R8");
        @(negedge clk);
        soft_run = 1'b0;
        conv_en  = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 reset held", int'(conv_rst_n), 0);
        chk("R4 ready held", int'(pwr_rdy), 0);
        conv_en = 1'b0;
        run_and_time(2 + BASE, "R4", 1'b0);

        // R6: drop enable while running
        @(negedge clk);
        conv_en = 1'b0;
        #1;
        chk("R6 reset same cycle", int'(conv_rst_n), 0);
        chk("R6 ready before edge", int'(pwr_rdy), 1);
        @(negedge clk);
        chk("R6 ready after edge", int'(pwr_rdy), 0);
        // drop during hold, then full restart
        @(negedge clk);
        conv_en = 1'b1;
        repeat (4) @(negedge clk);
        conv_en = 1'b0;
        @(negedge clk);
        run_and_time(2 + BASE, "R6 restart", 1'b0);
        stop_en();

        // R7: load commits mid-count; count uses captured value
        ext_stage = 6'd40;
        run_and_time(2 + BASE, "R7", 1'b1);
        chk("R7 new active", int'(ext_active), 40);
        chk("R5 ready with reset", int'(pwr_rdy), int'(conv_rst_n));
        stop_en();
        run_and_time(40 + BASE, "R7 next start", 1'b0);
        stop_en();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule